// File: doc/BRIEF.md
# Slave Port Cell-Available Poll Responder

This block answers the cell-available polls that a bus master issues on a cell-stream receive port built in the UTOPIA Level 2 style, when the device holding the block acts as the slave on that bus. Each clock the master may present an address-valid strobe together with a decoded port-select that says the polled address belongs to this port. The block registers that poll and, one clock later, answers with a cell-available bit and an active-low pad enable for that bit.

The answer is computed from per-channel state supplied by the channel selector: one "cell present" flag and one "masked" flag per logical channel, plus a flag that says the prefetch of the next channel has completed. The port reports a cell as available only when at least one unmasked channel holds a cell and that prefetch is done. When the master-select configuration input is high the port is a bus master, and this responder stays silent: its enable remains inactive and its cell-available bit remains low.

The pad enable is active only in the cycle that follows a poll addressed to this port. In every other cycle the pad is released and the cell-available bit is held low, so the value behind a released pad is always defined. Polls may come back to back, and each one is answered in its own cycle.

Top module: `cell_poll_responder`

## Requirements
- R1: While reset is high, and in the first cycle after the edge that samples it, the pad enable `cav_oe_n` is 1 (released) and `cav` is 0.
- R2: When `master_mode` is sampled 1, `cav_oe_n` is 1 and `cav` is 0 in the next cycle, whatever the other inputs are.
- R3: When `master_mode` is 0 and `addr_valid` and `port_sel` are both sampled 1, `cav_oe_n` is 0 in the next cycle.
- R4: When `addr_valid` is sampled 0, `cav_oe_n` is 1 and `cav` is 0 in the next cycle, even if `port_sel` is 1.
- R5: When `addr_valid` is sampled 1 and `port_sel` 0, `cav_oe_n` is 1 and `cav` is 0 in the next cycle.
- R6: In the cycle after a poll addressed to this port, `cav` is 1 exactly when some channel i has `ch_has_cell[i]`=1 and `ch_mask[i]`=0 (mask bit 1 means masked) and `prefetch_done` was 1, all sampled on the polling edge.
- R7: When `prefetch_done` is sampled 0 during a poll, `cav` is 0 in the next cycle while `cav_oe_n` is 0.
- R8: `cav` and `cav_oe_n` change on the same clock edge, and `cav` is never 1 while `cav_oe_n` is 1.
- R9: Polls in consecutive cycles are each answered one cycle after their own sampling edge, with no gap cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-port clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = port is bus master (responder silent), 0 = slave |
| addr_valid | input | 1 | Master's poll address-valid strobe, active high |
| port_sel | input | 1 | Decoded select: polled address belongs to this port |
| ch_has_cell | input | NUM_CH | Per-channel cell-present flags from the channel selector |
| ch_mask | input | NUM_CH | Per-channel mask flags, 1 = excluded from polling |
| prefetch_done | input | 1 | Next-channel prefetch has completed |
| cav | output | 1 | Registered cell-available answer |
| cav_oe_n | output | 1 | Registered active-low pad enable for `cav` |

## Verification
Every result of this block is due exactly one clock after the rising edge that samples the poll: the enable and the cell-available bit both come out of flops loaded on that edge. The bench therefore applies each poll on a falling edge, lets one rising edge pass, and reads both outputs one nanosecond after it, before the next falling edge changes anything. Back-to-back poll sequences are checked cycle by cycle in the same way, so that a stale or delayed answer shows up as a mismatch in the cycle it belongs to.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;

  // Registered answer for one poll cycle.
  typedef struct packed {
    logic drive;   // 1 = pad enabled for this cycle
    logic avail;   // cell-available value on the pad
  } poll_resp_t;

  localparam poll_resp_t RESP_IDLE = '{drive: 1'b0, avail: 1'b0};

endpackage

// File: rtl/masked_any.sv
module masked_any #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] has_cell,
  input  logic [NUM_CH-1:0] mask,
  output logic              any_ready
);

  logic [NUM_CH-1:0] hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = has_cell[g] & ~mask[g];
  end

  assign any_ready = |hit;

endmodule

// File: rtl/poll_gate.sv
module poll_gate
  import poll_resp_pkg::*;
(
  input  logic       master_mode,
  input  logic       addr_valid,
  input  logic       port_sel,
  input  logic       any_ready,
  input  logic       prefetch_done,
  output poll_resp_t next_resp
);

  logic addressed;

  always_comb begin
    addressed        = ~master_mode & addr_valid & port_sel;
    next_resp        = RESP_IDLE;
    next_resp.drive  = addressed;
    next_resp.avail  = addressed & any_ready & prefetch_done;
  end

endmodule

// File: rtl/poll_out_reg.sv
module poll_out_reg
  import poll_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  poll_resp_t next_resp,
  output logic       cav,
  output logic       cav_oe_n
);

  poll_resp_t resp_q;

  always_ff @(posedge clk) begin
    if (rst) resp_q <= RESP_IDLE;
    else     resp_q <= next_resp;
  end

  assign cav      = resp_q.avail;
  assign cav_oe_n = ~resp_q.drive;

  // R8: value is never high behind a released pad
  p_quiet_when_released_r8: assert property (@(posedge clk) disable iff (rst)
    cav_oe_n |-> !cav);

  // R1: reset releases the pad on the following cycle
  p_reset_release_r1: assert property (@(posedge clk)
    rst |=> (cav_oe_n && !cav));

endmodule

// File: rtl/cell_poll_responder.sv
module cell_poll_responder
  import poll_resp_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              addr_valid,
  input  logic              port_sel,
  input  logic [NUM_CH-1:0] ch_has_cell,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic              prefetch_done,
  output logic              cav,
  output logic              cav_oe_n
);

  logic       any_ready;
  poll_resp_t next_resp;

  masked_any #(.NUM_CH(NUM_CH)) u_any (
    .has_cell  (ch_has_cell),
    .mask      (ch_mask),
    .any_ready (any_ready)
  );

  poll_gate u_gate (
    .master_mode   (master_mode),
    .addr_valid    (addr_valid),
    .port_sel      (port_sel),
    .any_ready     (any_ready),
    .prefetch_done (prefetch_done),
    .next_resp     (next_resp)
  );

  poll_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .next_resp (next_resp),
    .cav       (cav),
    .cav_oe_n  (cav_oe_n)
  );

  // R2: master mode keeps the responder silent
  p_master_silent_r2: assert property (@(posedge clk) disable iff (rst)
    master_mode |=> (cav_oe_n && !cav));

  // R3 / R9: an addressed poll enables the pad on the next cycle
  p_poll_enables_r3: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && addr_valid && port_sel) |=> !cav_oe_n);

  // R4: no address strobe, pad released next cycle
  p_release_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> (cav_oe_n && !cav));

  // R5: strobe for another port leaves the pad released
  p_other_port_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !port_sel) |=> cav_oe_n);

  // R7: unfinished prefetch never reports a cell
  p_no_cell_before_prefetch_r7: assert property (@(posedge clk) disable iff (rst)
    !prefetch_done |=> !cav);

  // R6: an unmasked cell with prefetch done reports available
  p_cell_reported_r6: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && addr_valid && port_sel && prefetch_done
     && ((ch_has_cell & ~ch_mask) != '0)) |=> cav);

endmodule

// File: tb/test_cell_poll_responder.sv
`timescale 1ns/1ps
module test_cell_poll_responder;

  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           master_mode = 1'b0;
  logic           addr_valid = 1'b0;
  logic           port_sel = 1'b0;
  logic [NCH-1:0] ch_has_cell = '0;
  logic [NCH-1:0] ch_mask = '0;
  logic           prefetch_done = 1'b0;
  logic           cav;
  logic           cav_oe_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cell_poll_responder #(.NUM_CH(NCH)) i_cell_poll_responder (
    .clk(clk), .rst(rst), .master_mode(master_mode), .addr_valid(addr_valid),
    .port_sel(port_sel), .ch_has_cell(ch_has_cell), .ch_mask(ch_mask),
    .prefetch_done(prefetch_done), .cav(cav), .cav_oe_n(cav_oe_n)
  );

  task automatic check(input string req, input logic exp_oe_n, input logic exp_cav);
    checks++;
    if (cav_oe_n !== exp_oe_n || cav !== exp_cav) begin
      errors++;
      $display("FAIL %s: oe_n=%b cav=%b expected oe_n=%b cav=%b",
               req, cav_oe_n, cav, exp_oe_n, exp_cav);
    end
  endtask

  // Drive one cycle of inputs on the falling edge, sample after the next rise.
  task automatic poll(input logic mm, input logic av, input logic sel,
                      input logic [NCH-1:0] has, input logic [NCH-1:0] msk,
                      input logic pf);
    @(negedge clk);
    master_mode = mm; addr_valid = av; port_sel = sel;
    ch_has_cell = has; ch_mask = msk; prefetch_done = pf;
    @(posedge clk);
    #1;
  endtask

  function automatic logic model_cav(input logic mm, input logic av, input logic sel,
                                     input logic [NCH-1:0] has, input logic [NCH-1:0] msk,
                                     input logic pf);
    logic any;
    any = 1'b0;
    for (int i = 0; i < NCH; i++) if (has[i] && !msk[i]) any = 1'b1;
    return !mm && av && sel && pf && any;
  endfunction

  task automatic t_reset_r1;
    @(negedge clk);
    rst = 1'b1; master_mode = 1'b0; addr_valid = 1'b1; port_sel = 1'b1;
    ch_has_cell = '1; prefetch_done = 1'b1;
    @(posedge clk); #1;
    check("R1 in reset", 1'b1, 1'b0);
    @(negedge clk); rst = 1'b0; addr_valid = 1'b0; port_sel = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", 1'b1, 1'b0);
  endtask

  task automatic t_master_r2;
    poll(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b1);
    check("R2 master silent", 1'b1, 1'b0);
    poll(1'b1, 1'b1, 1'b1, 8'h01, 8'h00, 1'b1);
    check("R2 master silent again", 1'b1, 1'b0);
  endtask

  task automatic t_addressed_r3;
    poll(1'b0, 1'b1, 1'b1, 8'h10, 8'h00, 1'b1);
    check("R3 addressed poll with cell", 1'b0, 1'b1);
    poll(1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1);
    check("R3 addressed poll no cell", 1'b0, 1'b0);
  endtask

  task automatic t_no_strobe_r4;
    poll(1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1);
    check("R4 strobe low select high", 1'b1, 1'b0);
    poll(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1);
    check("R4 strobe low select low", 1'b1, 1'b0);
  endtask

  task automatic t_other_port_r5;
    poll(1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b1);
    check("R5 other port polled", 1'b1, 1'b0);
  endtask

  task automatic t_mask_r6;
    poll(1'b0, 1'b1, 1'b1, 8'h0C, 8'h0C, 1'b1);
    check("R6 all cells masked", 1'b0, 1'b0);
    poll(1'b0, 1'b1, 1'b1, 8'h0C, 8'h04, 1'b1);
    check("R6 one unmasked cell", 1'b0, 1'b1);
    poll(1'b0, 1'b1, 1'b1, 8'h80, 8'h7F, 1'b1);
    check("R6 top channel only", 1'b0, 1'b1);
    poll(1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1);
    check("R6 masked empty", 1'b0, 1'b0);
  endtask

  task automatic t_prefetch_r7;
    poll(1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0);
    check("R7 prefetch pending", 1'b0, 1'b0);
    poll(1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b1);
    check("R7 prefetch finished", 1'b0, 1'b1);
  endtask

  task automatic t_same_edge_r8;
    // enable and value must rise together and fall together
    poll(1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 1'b1);
    check("R8 idle before", 1'b1, 1'b0);
    poll(1'b0, 1'b1, 1'b1, 8'h01, 8'h00, 1'b1);
    check("R8 both change together on", 1'b0, 1'b1);
    poll(1'b0, 1'b0, 1'b1, 8'h01, 8'h00, 1'b1);
    check("R8 both change together off", 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back_r9;
    logic [NCH-1:0] hs [6];
    logic           sl [6];
    logic           pf [6];
    hs = '{8'h01, 8'h00, 8'h20, 8'h20, 8'hF0, 8'h02};
    sl = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    pf = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    for (int k = 0; k < 6; k++) begin
      poll(1'b0, 1'b1, sl[k], hs[k], 8'h10, pf[k]);
      check($sformatf("R9 consecutive poll %0d", k), !sl[k],
            model_cav(1'b0, 1'b1, sl[k], hs[k], 8'h10, pf[k]));
    end
  endtask

  initial begin
    t_reset_r1();
    t_master_r2();
    t_addressed_r3();
    t_no_strobe_r4();
    t_other_port_r5();
    t_mask_r6();
    t_prefetch_r7();
    t_same_edge_r8();
    t_back_to_back_r9();
    poll(1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule